// File: doc/BRIEF.md
# Per-Thread Load Miss Queue

This block sits beside a multithreaded core's data cache and keeps track of loads that missed. Every hardware thread owns a private group of primary slots, so one thread that piles up misses cannot take capacity from another. When the memory stage reports a miss, the block compares the cache-line part of the address against every outstanding primary entry of every thread. The byte offset inside the line is not part of that compare.

A miss to a line that is not yet outstanding takes a slot in its thread's group. It also queues one line request toward the shared second-level cache. A miss to a line that is already outstanding goes into a shared wait buffer instead. It takes no thread slot and sends no request.

When a line fill comes back, the block drains every load waiting on that line. It first wakes the primary entry, then each matching wait-buffer entry, one per cycle. Each wake carries the thread number, the full load address and the load tag, so the pipeline can replay the load. A thread whose group is full is refused, and a per-thread counter records how many cycles such a refused miss was presented.

Top module: `ld_miss_queue`

## Requirements
- R1: After reset: `l2_req_valid` and `wake_valid` are low; `thread_full` is all zero; `miss_ready` and `fill_ready` are high; every stall counter is zero.
- R2: A miss to a new line is accepted and produces exactly one L2 request.
  - The request carries the line address, which is address bits above OFFW.
  - Requests leave in acceptance order.
  - While `l2_req_valid` is high and `l2_req_ready` is low, the request line holds steady.
- R3: A miss whose line equals that of any valid primary entry, of any thread and with any offset, is a duplicate.
  - A duplicate is accepted into the wait buffer.
  - It creates no L2 request and occupies no thread slot.
- R4: Each thread holds at most DEPTH primary entries.
  - `thread_full[t]` goes high in the cycle after the edge that fills the last slot of thread t.
  - While it is high, a miss for thread t sees `miss_ready` low.
  - Other threads are not affected.
- R5: Stall counting is per thread.
  - The counter for thread t, at `stall_count[t*CNTW +: CNTW]`, rises by one for each clock edge at which a miss for t is presented while t is full.
  - With STALL_SAT set, the counter stops at its all-ones value.
- R6: A fill is taken when `fill_valid` and `fill_ready` are both high.
  - From the next cycle until the drain ends, `fill_ready` and `miss_ready` are low.
- R7: In the first cycle after a fill is taken, the block wakes the primary entry of that line and frees its slot.
  - It then wakes each matching wait-buffer entry, one per cycle, lowest slot first.
  - `fill_ready` returns high in the cycle after the last wake.
- R8: Wait-buffer slots are filled lowest free slot first. When all WBD slots are taken, a duplicate miss is refused.
- R9: A fill leaves wait-buffer entries for other lines untouched; they still wake on their own line's fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | A load miss is presented |
| miss_tid | input | TIDW | Thread of the miss |
| miss_addr | input | AW | Full load address |
| miss_tag | input | TAGW | Load identifier returned on wake |
| miss_ready | output | 1 | Miss accepted this cycle |
| thread_full | output | NT | Per-thread group full |
| stall_count | output | NT*CNTW | Per-thread full-stall cycle counters |
| l2_req_valid | output | 1 | Line request pending |
| l2_req_ready | input | 1 | L2 takes the request |
| l2_req_line | output | AW-OFFW | Requested line address |
| fill_valid | input | 1 | Line fill returned |
| fill_line | input | AW-OFFW | Line address of the fill |
| fill_ready | output | 1 | Fill can be taken |
| wake_valid | output | 1 | A waiting load is released |
| wake_tid | output | TIDW | Thread of the released load |
| wake_addr | output | AW | Address of the released load |
| wake_tag | output | TAGW | Tag of the released load |

## Verification
The assertions assume the environment follows four rules:
- every fill answers a request that was already sent;
- no second fill arrives for a line while its drain is running;
- `miss_tid` stays below NT;
- `l2_req_ready` may be low for any number of cycles.

The stimulus keeps to all four. It raises `fill_valid` only for lines whose requests were popped earlier, and only while `fill_ready` is high. It uses thread numbers 0 and 1 of a two-thread configuration. It holds `l2_req_ready` low across several cycles before draining requests.

// File: rtl/lmq_pkg.sv
`timescale 1ns/1ps
package lmq_pkg;
   typedef enum logic [1:0] {
      DRN_IDLE    = 2'd0,
      DRN_PRIMARY = 2'd1,
      DRN_WAITERS = 2'd2
   } drain_state_e;
endpackage

// File: rtl/lmq_slot_pool.sv
`timescale 1ns/1ps
// Pool of SLOTS entries; insert takes the lowest free slot, delete frees by index.
module lmq_slot_pool #(
   parameter int unsigned SLOTS = 2,
   parameter int unsigned PW    = 8,
   localparam int unsigned IW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ins_en,
   input  logic [PW-1:0]         ins_data,
   input  logic                  del_en,
   input  logic [IW-1:0]         del_idx,
   output logic [SLOTS-1:0]      occ,
   output logic [SLOTS*PW-1:0]   data_flat,
   output logic                  full
);
   logic [SLOTS-1:0]    occ_q;
   logic [SLOTS*PW-1:0] data_q;
   logic [IW-1:0]       ins_idx;

   always_comb begin
      ins_idx = '0;
      for (int i = SLOTS - 1; i >= 0; i--) begin
         if (!occ_q[i]) ins_idx = IW'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q  <= '0;
         data_q <= '0;
      end else begin
         for (int i = 0; i < SLOTS; i++) begin
            if (del_en && del_idx == IW'(i)) occ_q[i] <= 1'b0;
            if (ins_en && !full && ins_idx == IW'(i)) begin
               occ_q[i]            <= 1'b1;
               data_q[i*PW +: PW]  <= ins_data;
            end
         end
      end
   end

   assign occ       = occ_q;
   assign data_flat = data_q;
   assign full      = &occ_q;
endmodule

// File: rtl/lmq_req_fifo.sv
`timescale 1ns/1ps
// Ordered queue of outgoing line requests.
module lmq_req_fifo #(
   parameter int unsigned DEPTH = 4,
   parameter int unsigned W     = 12,
   localparam int unsigned PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic         out_valid,
   output logic [W-1:0] out_data
);
   logic [W-1:0]    mem [DEPTH];
   logic [PTRW-1:0] rd_ptr, wr_ptr;
   logic [CNTW-1:0] cnt;
   logic            do_push, do_pop;

   function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
      return (p == PTRW'(DEPTH - 1)) ? '0 : p + PTRW'(1);
   endfunction

   assign out_valid = (cnt != '0);
   assign out_data  = mem[rd_ptr];
   assign do_pop    = pop && out_valid;
   assign do_push   = push && (cnt != CNTW'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         cnt    <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         if (do_push) begin
            mem[wr_ptr] <= push_data;
            wr_ptr      <= bump(wr_ptr);
         end
         if (do_pop) rd_ptr <= bump(rd_ptr);
         if (do_push && !do_pop)      cnt <= cnt + CNTW'(1);
         else if (do_pop && !do_push) cnt <= cnt - CNTW'(1);
      end
   end
endmodule

// File: rtl/ld_miss_queue.sv
`timescale 1ns/1ps
module ld_miss_queue #(
   parameter int unsigned NT        = 2,
   parameter int unsigned DEPTH     = 2,
   parameter int unsigned AW        = 16,
   parameter int unsigned OFFW      = 4,
   parameter int unsigned TAGW      = 4,
   parameter int unsigned WBD       = 4,
   parameter int unsigned CNTW      = 8,
   parameter bit          STALL_SAT = 1'b1,
   localparam int unsigned TIDW     = (NT > 1) ? $clog2(NT) : 1,
   localparam int unsigned LW       = AW - OFFW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 miss_valid,
   input  logic [TIDW-1:0]      miss_tid,
   input  logic [AW-1:0]        miss_addr,
   input  logic [TAGW-1:0]      miss_tag,
   output logic                 miss_ready,
   output logic [NT-1:0]        thread_full,
   output logic [NT*CNTW-1:0]   stall_count,
   output logic                 l2_req_valid,
   input  logic                 l2_req_ready,
   output logic [LW-1:0]        l2_req_line,
   input  logic                 fill_valid,
   input  logic [LW-1:0]        fill_line,
   output logic                 fill_ready,
   output logic                 wake_valid,
   output logic [TIDW-1:0]      wake_tid,
   output logic [AW-1:0]        wake_addr,
   output logic [TAGW-1:0]      wake_tag
);
   import lmq_pkg::*;

   localparam int unsigned BPW  = AW + TAGW;          // bank payload {addr, tag}
   localparam int unsigned WPW  = TIDW + AW + TAGW;   // wait payload {tid, addr, tag}
   localparam int unsigned BIW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned WIW  = (WBD > 1) ? $clog2(WBD) : 1;
   localparam int unsigned WCW  = $clog2(WBD + 1);
   localparam int unsigned RQD  = NT * DEPTH;

   initial begin
      assert (NT >= 1) else $error("NT must be at least 1");
      assert (DEPTH >= 1 && DEPTH <= 8) else $error("DEPTH must be 1..8");
      assert (OFFW < AW) else $error("OFFW must be below AW");
      assert (WBD >= 1) else $error("WBD must be at least 1");
      assert (TAGW >= 1 && CNTW >= 1) else $error("TAGW and CNTW must be nonzero");
   end

   drain_state_e    st_q;
   logic [LW-1:0]   fill_line_q;
   logic [LW-1:0]   miss_line;
   assign miss_line = miss_addr[AW-1:OFFW];

   // ---------------- per-thread primary banks ----------------
   logic [DEPTH-1:0]     bank_occ  [NT];
   logic [DEPTH*BPW-1:0] bank_data [NT];
   logic [NT-1:0]        bank_ins, bank_del;
   logic [BIW-1:0]       bank_del_idx;

   for (genvar t = 0; t < NT; t++) begin : g_thr
      logic [CNTW-1:0] stall_q;
      logic            stall_hit;

      lmq_slot_pool #(.SLOTS(DEPTH), .PW(BPW)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .ins_en    (bank_ins[t]),
         .ins_data  ({miss_addr, miss_tag}),
         .del_en    (bank_del[t]),
         .del_idx   (bank_del_idx),
         .occ       (bank_occ[t]),
         .data_flat (bank_data[t]),
         .full      (thread_full[t])
      );

      assign stall_hit = miss_valid && (miss_tid == TIDW'(t)) && thread_full[t];

      if (STALL_SAT) begin : g_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         stall_q <= '0;
            else if (stall_hit && stall_q != '1) stall_q <= stall_q + CNTW'(1);
         end
      end else begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         stall_q <= '0;
            else if (stall_hit) stall_q <= stall_q + CNTW'(1);
         end
      end

      assign stall_count[t*CNTW +: CNTW] = stall_q;
   end

   // ---------------- shared wait buffer ----------------
   logic [WBD-1:0]     wb_occ;
   logic [WBD*WPW-1:0] wb_data;
   logic               wb_full, wb_ins, wb_del;
   logic [WIW-1:0]     wb_del_idx;

   lmq_slot_pool #(.SLOTS(WBD), .PW(WPW)) u_wait (
      .clk       (clk),
      .rst_n     (rst_n),
      .ins_en    (wb_ins),
      .ins_data  ({miss_tid, miss_addr, miss_tag}),
      .del_en    (wb_del),
      .del_idx   (wb_del_idx),
      .occ       (wb_occ),
      .data_flat (wb_data),
      .full      (wb_full)
   );

   // ---------------- line compares ----------------
   logic            dup, sel_full, tid_ok;
   logic            fm_any;
   logic [TIDW-1:0] fm_tid;
   logic [BIW-1:0]  fm_idx;
   logic [BPW-1:0]  fm_pay;

   always_comb begin
      dup = 1'b0; fm_any = 1'b0; fm_tid = '0; fm_idx = '0; fm_pay = '0; sel_full = 1'b0;
      for (int t = 0; t < NT; t++) begin
         if (miss_tid == TIDW'(t)) sel_full = thread_full[t];
         for (int i = 0; i < DEPTH; i++) begin
            if (bank_occ[t][i]) begin
               if (bank_data[t][i*BPW + TAGW + OFFW +: LW] == miss_line) dup = 1'b1;
               if (!fm_any && bank_data[t][i*BPW + TAGW + OFFW +: LW] == fill_line_q) begin
                  fm_any = 1'b1;
                  fm_tid = TIDW'(t);
                  fm_idx = BIW'(i);
                  fm_pay = bank_data[t][i*BPW +: BPW];
               end
            end
         end
      end
   end

   logic [WCW-1:0] wm_cnt;
   logic           wm_any;
   logic [WPW-1:0] wm_pay;

   always_comb begin
      wm_cnt = '0; wm_any = 1'b0; wb_del_idx = '0; wm_pay = '0;
      for (int i = 0; i < WBD; i++) begin
         if (wb_occ[i] && wb_data[i*WPW + TAGW + OFFW +: LW] == fill_line_q) begin
            wm_cnt = wm_cnt + WCW'(1);
            if (!wm_any) begin
               wm_any     = 1'b1;
               wb_del_idx = WIW'(i);
               wm_pay     = wb_data[i*WPW +: WPW];
            end
         end
      end
   end

   // ---------------- miss acceptance ----------------
   logic acc;
   assign tid_ok     = ({1'b0, miss_tid} < (TIDW+1)'(NT));
   assign miss_ready = (st_q == DRN_IDLE) && tid_ok && !sel_full && !(dup && wb_full);
   assign acc        = miss_valid && miss_ready;
   assign wb_ins     = acc && dup;

   always_comb begin
      for (int t = 0; t < NT; t++) begin
         bank_ins[t] = acc && !dup && (miss_tid == TIDW'(t));
         bank_del[t] = (st_q == DRN_PRIMARY) && fm_any && (fm_tid == TIDW'(t));
      end
   end
   assign bank_del_idx = fm_idx;
   assign wb_del       = (st_q == DRN_WAITERS) && wm_any;

   lmq_req_fifo #(.DEPTH(RQD), .W(LW)) u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (acc && !dup),
      .push_data (miss_line),
      .pop       (l2_req_ready),
      .out_valid (l2_req_valid),
      .out_data  (l2_req_line)
   );

   // ---------------- fill drain ----------------
   assign fill_ready = (st_q == DRN_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= DRN_IDLE;
         fill_line_q <= '0;
      end else begin
         case (st_q)
            DRN_IDLE: if (fill_valid) begin
               st_q        <= DRN_PRIMARY;
               fill_line_q <= fill_line;
            end
            DRN_PRIMARY: st_q <= (wm_cnt != '0) ? DRN_WAITERS : DRN_IDLE;
            DRN_WAITERS: if (wm_cnt <= WCW'(1)) st_q <= DRN_IDLE;
            default:     st_q <= DRN_IDLE;
         endcase
      end
   end

   always_comb begin
      wake_valid = 1'b0;
      wake_tid   = '0;
      wake_addr  = '0;
      wake_tag   = '0;
      if (st_q == DRN_PRIMARY) begin
         wake_valid = fm_any;
         wake_tid   = fm_tid;
         wake_addr  = fm_pay[TAGW +: AW];
         wake_tag   = fm_pay[TAGW-1:0];
      end else if (st_q == DRN_WAITERS) begin
         wake_valid = wm_any;
         wake_tid   = wm_pay[TAGW + AW +: TIDW];
         wake_addr  = wm_pay[TAGW +: AW];
         wake_tag   = wm_pay[TAGW-1:0];
      end
   end
endmodule

// File: rtl/ld_miss_queue_chk.sv
`timescale 1ns/1ps
module ld_miss_queue_chk #(
   parameter int unsigned NT   = 2,
   parameter int unsigned TIDW = 1,
   parameter int unsigned LW   = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            miss_valid,
   input logic [TIDW-1:0] miss_tid,
   input logic            miss_ready,
   input logic [NT-1:0]   thread_full,
   input logic            l2_req_valid,
   input logic            l2_req_ready,
   input logic [LW-1:0]   l2_req_line,
   input logic            fill_valid,
   input logic            fill_ready,
   input logic            wake_valid
);
   logic own_full;
   always_comb begin
      own_full = 1'b0;
      for (int t = 0; t < NT; t++)
         if (miss_tid == TIDW'(t)) own_full = thread_full[t];
   end

   AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      miss_valid && own_full |-> !miss_ready);                         // R4
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      l2_req_valid && !l2_req_ready |=> l2_req_valid && $stable(l2_req_line)); // R2
   AST_FILL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid && fill_ready |=> !fill_ready);                       // R6
   AST_DRAIN_BLOCKS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_ready |-> !miss_ready);                                    // R6
   AST_WAKE_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid |-> !fill_ready);                                     // R7
endmodule

bind ld_miss_queue ld_miss_queue_chk #(.NT(NT), .TIDW(TIDW), .LW(LW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .miss_valid   (miss_valid),
   .miss_tid     (miss_tid),
   .miss_ready   (miss_ready),
   .thread_full  (thread_full),
   .l2_req_valid (l2_req_valid),
   .l2_req_ready (l2_req_ready),
   .l2_req_line  (l2_req_line),
   .fill_valid   (fill_valid),
   .fill_ready   (fill_ready),
   .wake_valid   (wake_valid)
);

// File: tb/tb_ld_miss_queue.sv
`timescale 1ns/1ps
module tb_ld_miss_queue;
   localparam int NT = 2, DEPTH = 2, AW = 16, OFFW = 4, TAGW = 4, WBD = 4, CNTW = 8;
   localparam int TIDW = 1, LW = AW - OFFW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic miss_valid = 1'b0;
   logic [TIDW-1:0] miss_tid = '0;
   logic [AW-1:0]   miss_addr = '0;
   logic [TAGW-1:0] miss_tag = '0;
   logic miss_ready;
   logic [NT-1:0] thread_full;
   logic [NT*CNTW-1:0] stall_count;
   logic l2_req_valid, l2_req_ready = 1'b0;
   logic [LW-1:0] l2_req_line;
   logic fill_valid = 1'b0;
   logic [LW-1:0] fill_line = '0;
   logic fill_ready, wake_valid;
   logic [TIDW-1:0] wake_tid;
   logic [AW-1:0] wake_addr;
   logic [TAGW-1:0] wake_tag;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   ld_miss_queue #(.NT(NT), .DEPTH(DEPTH), .AW(AW), .OFFW(OFFW), .TAGW(TAGW),
                   .WBD(WBD), .CNTW(CNTW)) dut (.*);

   always #2.5 clk = ~clk;

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic miss(int tid, int addr, int tag, bit exp_rdy, string req);
      @(negedge clk);
      miss_valid = 1'b1; miss_tid = TIDW'(tid); miss_addr = AW'(addr); miss_tag = TAGW'(tag);
      #0.5 chk(req, "miss_ready", miss_ready, exp_rdy);
      @(posedge clk); #0.5 miss_valid = 1'b0;
   endtask

   task automatic fill(int line);
      @(negedge clk);
      chk("R6", "fill_ready before fill", fill_ready, 1);
      fill_valid = 1'b1; fill_line = LW'(line);
      @(posedge clk); #0.5 fill_valid = 1'b0;
   endtask

   task automatic wake(int tid, int addr, int tag, string req);
      @(negedge clk);
      chk(req, "wake_valid", wake_valid, 1);
      chk(req, "wake_tid", wake_tid, tid);
      chk(req, "wake_addr", wake_addr, addr);
      chk(req, "wake_tag", wake_tag, tag);
      chk("R6", "fill_ready in drain", fill_ready, 0);
   endtask

   task automatic drain_end(string req);
      @(negedge clk);
      chk(req, "wake_valid after drain", wake_valid, 0);
      chk(req, "fill_ready after drain", fill_ready, 1);
   endtask

   task automatic pop_req(int line, string req);
      @(negedge clk);
      l2_req_ready = 1'b1;
      chk(req, "l2_req_valid", l2_req_valid, 1);
      chk(req, "l2_req_line", l2_req_line, line);
      @(posedge clk); #0.5 l2_req_ready = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #0.5 rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "l2_req_valid", l2_req_valid, 0);
      chk("R1", "wake_valid", wake_valid, 0);
      chk("R1", "thread_full", thread_full, 0);
      chk("R1", "miss_ready", miss_ready, 1);
      chk("R1", "fill_ready", fill_ready, 1);
      chk("R1", "stall_count", stall_count, 0);

      miss(0, 'h1230, 1, 1, "R2");
      miss(0, 'h1238, 2, 1, "R3");           // same line, other offset
      @(negedge clk) chk("R3", "t0 not full after dup", thread_full[0], 0);
      miss(0, 'h4560, 3, 1, "R2");
      @(negedge clk) chk("R4", "t0 full", thread_full[0], 1);
      miss(1, 'h7890, 4, 1, "R4");           // other thread unaffected
      miss(1, 'h4561, 5, 1, "R3");           // cross-thread duplicate

      // refused miss held for three edges
      @(negedge clk);
      miss_valid = 1'b1; miss_tid = 0; miss_addr = 16'h9990; miss_tag = 4'hF;
      #0.5 chk("R4", "refused when full", miss_ready, 0);
      repeat (3) @(posedge clk);
      #0.5 miss_valid = 1'b0;
      @(negedge clk) chk("R5", "t0 stall", stall_count[7:0], 3);

      // request ordering and hold
      @(negedge clk);
      chk("R2", "first req", l2_req_line, 'h123);
      @(negedge clk);
      chk("R2", "req held", l2_req_line, 'h123);
      pop_req('h123, "R2");
      pop_req('h456, "R2");
      pop_req('h789, "R2");
      @(negedge clk) chk("R3", "no request for duplicates", l2_req_valid, 0);

      // fill of line 0x456: primary t0, then waiter t1
      fill('h456);
      wake(0, 'h4560, 3, "R7");
      miss_valid = 1'b1; miss_tid = 1; miss_addr = 16'hAAA0;
      #0.5 chk("R6", "miss blocked in drain", miss_ready, 0);
      miss_valid = 1'b0;
      wake(1, 'h4561, 5, "R7");
      drain_end("R7");
      chk("R7", "t0 slot freed", thread_full[0], 0);

      // fill of line 0x123: waiter survived previous fill
      fill('h123);
      wake(0, 'h1230, 1, "R7");
      wake(0, 'h1238, 2, "R9");
      drain_end("R9");

      // wait buffer capacity
      for (int k = 0; k < WBD; k++) miss(0, 'h7890 + k, 6 + k, 1, "R8");
      miss(0, 'h789F, 'hA, 0, "R8");
      @(negedge clk) chk("R3", "no request for parked dups", l2_req_valid, 0);
      fill('h789);
      wake(1, 'h7890, 4, "R7");
      for (int k = 0; k < WBD; k++) wake(0, 'h7890 + k, 6 + k, "R8");
      drain_end("R7");

      // thread 1 full, thread 0 still served, counter saturation
      miss(1, 'hC000, 'hB, 1, "R2");
      miss(1, 'hD000, 'hC, 1, "R2");
      @(negedge clk);
      chk("R4", "t1 full", thread_full[1], 1);
      chk("R4", "t0 not full", thread_full[0], 0);
      miss(0, 'hE000, 'hD, 1, "R4");
      @(negedge clk);
      miss_valid = 1'b1; miss_tid = 1; miss_addr = 16'hF000;
      repeat (300) @(posedge clk);
      #0.5 miss_valid = 1'b0;
      @(negedge clk);
      chk("R5", "t1 stall saturates", stall_count[15:8], 255);
      chk("R5", "t0 stall unchanged", stall_count[7:0], 3);
      pop_req('hC00, "R2");
      pop_req('hD00, "R2");
      pop_req('hE00, "R2");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         errors++;
         checks++;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule